// File: doc/BRIEF.md
# Lockstep SIMD Array Processing Element

This block is one worker of a lockstep SIMD array. A central sequencer broadcasts the same instruction to every element in the same cycle. Each element applies it to its own registers, its own local memory and its own multiply-accumulator. An instruction is one opcode, a destination register, two source registers and a 16-bit immediate. The low bits of the immediate serve as a memory address, a shift amount or a neighbour selector.

Elements trade 16-bit words through a four-way neighbour mesh. The array ties opposite edges of that mesh together, which turns it into a torus. Each element presents one registered outgoing word, which is loaded by an explicit send instruction. A receive instruction copies the outgoing word of one chosen neighbour into a register in a single cycle. A pixel input can be copied into a register, and because every element does this in the same instruction, the whole image is captured at one moment.

Two gates decide whether an element acts. The first is a per-cycle enable driven by the sequencer. The second is a local activity flag, which the element sets from its own data. A disabled element writes nothing, but it keeps driving its outgoing word to its neighbours.

Top module: `simd_pe`

## Requirements
- R1: After a synchronous active-high reset, the neighbour output is 0, the activity flag output is 1 and the accumulator holds 0.
- R2: ADD (1), SUB (2), ADDI (3, rs1 plus the immediate), AND (4), OR (5), XOR (6) and LDI (10, load the immediate) work on the low 16 bits of their operands. Each wraps modulo 2^16 and writes its result zero-extended into the 32-bit destination register.
- R3: SHL (7), SHR (8, logical) and SRA (9, arithmetic) shift the low 16 bits of rs1 by immediate bits [3:0], and write the result zero-extended into the destination.
- R4: MAC (13) adds the signed 16x16 product of rs1 and rs2 to a 32-bit accumulator, wrapping. ACLR (14) zeroes the accumulator. AHI (15) and ALO (16) write the upper and lower accumulator halves into rd. AMOV (22) copies the full accumulator into rd, and ALD (23) loads the accumulator from the full 32 bits of rs1.
- R5: ST (12) writes the low 16 bits of rs2 to local memory word immediate[5:0], and LD (11) reads that word back zero-extended. The local memory holds 64 words.
- R6: RECV (18) writes into rd the word from the neighbour picked by immediate[1:0]: 0 north, 1 east, 2 south, 3 west.
- R7: SAMP (19) writes the 8-bit pixel input, zero-extended, into rd.
- R8: SEND (17) places the low 16 bits of rs1 on the neighbour output after the clock edge that executes it. The output holds its value through every other instruction.
- R9: With the array enable low, an instruction changes no register, memory word, accumulator value, neighbour output or activity flag.
- R10: MNZ (20) sets the activity flag to whether the low 16 bits of rs1 are non-zero, and MALL (21) sets it to 1. Both run while the flag is 0. Every other instruction is suppressed while the flag is 0.
- R11: When the instruction-valid input is low, nothing changes, whatever the other instruction inputs hold.
- R12: A register written by one instruction is read with its new value by the instruction in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid_i | input | 1 | Broadcast instruction present this cycle |
| instr_op_i | input | 5 | Opcode |
| instr_rd_i | input | 4 | Destination register |
| instr_rs1_i | input | 4 | First source register |
| instr_rs2_i | input | 4 | Second source register |
| instr_imm_i | input | 16 | Immediate, memory address, shift amount or neighbour selector |
| mask_i | input | 1 | Array enable for this element |
| pix_i | input | 8 | Pixel sample value |
| nb_n_i | input | 16 | Outgoing word of the north neighbour |
| nb_e_i | input | 16 | Outgoing word of the east neighbour |
| nb_s_i | input | 16 | Outgoing word of the south neighbour |
| nb_w_i | input | 16 | Outgoing word of the west neighbour |
| nb_out_o | output | 16 | Registered outgoing word to all neighbours |
| act_o | output | 1 | Local activity flag |

## Verification
The bench targets the corner cases below, and each one names the failure it catches.
- Additions and subtractions that wrap at 16 bits catch a result leaking into the upper register half.
- An arithmetic shift of a negative word catches a design that fills with zeros where it should fill with the sign.
- Products of -1 by -1 and of two maximal positive words catch unsigned multiplication and a truncated accumulator.
- Instructions issued with the array enable low, with the activity flag cleared, and with valid low catch a gate that misses the memory, accumulator or output path, which would corrupt state the bench reads back later.
- Back-to-back dependent instructions catch a register file that returns stale data.
- All four neighbour selectors are exercised with distinct words, which catches swapped directions.

// File: rtl/simd_pe_pkg.sv
package simd_pe_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 5'd0,
    OP_ADD  = 5'd1,
    OP_SUB  = 5'd2,
    OP_ADDI = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_SHL  = 5'd7,
    OP_SHR  = 5'd8,
    OP_SRA  = 5'd9,
    OP_LDI  = 5'd10,
    OP_LD   = 5'd11,
    OP_ST   = 5'd12,
    OP_MAC  = 5'd13,
    OP_ACLR = 5'd14,
    OP_AHI  = 5'd15,
    OP_ALO  = 5'd16,
    OP_SEND = 5'd17,
    OP_RECV = 5'd18,
    OP_SAMP = 5'd19,
    OP_MNZ  = 5'd20,
    OP_MALL = 5'd21,
    OP_AMOV = 5'd22,
    OP_ALD  = 5'd23
  } op_e;

  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_E = 2'd1,
    DIR_S = 2'd2,
    DIR_W = 2'd3
  } dir_e;

endpackage

// File: rtl/simd_pe_regfile.sv
module simd_pe_regfile #(
  parameter int WIDTH  = 32,
  parameter int DEPTH  = 16,
  parameter int R2_W   = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr1,
  input  logic [AW-1:0]    raddr2,
  output logic [WIDTH-1:0] rdata1,
  output logic [R2_W-1:0]  rdata2
);

  logic [WIDTH-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign rdata1 = regs[raddr1];
  assign rdata2 = regs[raddr2][R2_W-1:0];

endmodule

// File: rtl/simd_pe_lmem.sv
module simd_pe_lmem #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[addr] <= wdata;
  end

  assign rdata = words[addr];

endmodule

// File: rtl/simd_pe_shifter.sv
module simd_pe_shifter #(
  parameter int WIDTH = 16,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SH_W-1:0]  amt,
  input  logic             left,
  input  logic             arith,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [SH_W+1];
  logic             fill;

  assign fill     = arith & din[WIDTH-1];
  assign stage[0] = din;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [WIDTH-1:0] to_left;
    logic [WIDTH-1:0] to_right;
    assign to_left  = stage[k] << STEP;
    assign to_right = (stage[k] >> STEP) | (fill ? ~({WIDTH{1'b1}} >> STEP) : '0);
    assign stage[k+1] = amt[k] ? (left ? to_left : to_right) : stage[k];
  end

  assign dout = stage[SH_W];

endmodule

// File: rtl/simd_pe_alu.sv
module simd_pe_alu
  import simd_pe_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int SH_W = $clog2(WIDTH)
) (
  input  op_e              op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] imm,
  output logic [WIDTH-1:0] res
);

  logic [WIDTH-1:0] sh_out;
  logic             sh_left;
  logic             sh_arith;

  assign sh_left  = (op == OP_SHL);
  assign sh_arith = (op == OP_SRA);

  simd_pe_shifter #(.WIDTH(WIDTH)) u_shift (
    .din   (a),
    .amt   (imm[SH_W-1:0]),
    .left  (sh_left),
    .arith (sh_arith),
    .dout  (sh_out)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_ADDI: res = a + imm;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_SHL,
      OP_SHR,
      OP_SRA:  res = sh_out;
      OP_LDI:  res = imm;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/simd_pe_mac.sv
module simd_pe_mac #(
  parameter int WIDTH = 16,
  parameter int ACC_W = 32,
  parameter int LD_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mac_en,
  input  logic             clr_en,
  input  logic             ld_en,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [LD_W-1:0]  ld_val,
  output logic [ACC_W-1:0] acc
);

  logic signed [2*WIDTH-1:0] prod;
  logic        [ACC_W-1:0]   acc_q;

  assign prod = $signed(a) * $signed(b);

  always_ff @(posedge clk) begin
    if (rst || clr_en) acc_q <= '0;
    else if (ld_en)    acc_q <= ACC_W'(ld_val);
    else if (mac_en)   acc_q <= acc_q + ACC_W'(prod);
  end

  assign acc = acc_q;

endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pe_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int RF_W      = 32,
  parameter int RF_DEPTH  = 16,
  parameter int MEM_DEPTH = 64,
  parameter int ACC_W     = 32,
  parameter int PIX_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        instr_valid_i,
  input  logic [OP_W-1:0]             instr_op_i,
  input  logic [$clog2(RF_DEPTH)-1:0] instr_rd_i,
  input  logic [$clog2(RF_DEPTH)-1:0] instr_rs1_i,
  input  logic [$clog2(RF_DEPTH)-1:0] instr_rs2_i,
  input  logic [DATA_W-1:0]           instr_imm_i,
  input  logic                        mask_i,
  input  logic [PIX_W-1:0]            pix_i,
  input  logic [DATA_W-1:0]           nb_n_i,
  input  logic [DATA_W-1:0]           nb_e_i,
  input  logic [DATA_W-1:0]           nb_s_i,
  input  logic [DATA_W-1:0]           nb_w_i,
  output logic [DATA_W-1:0]           nb_out_o,
  output logic                        act_o
);

  localparam int MEM_AW = $clog2(MEM_DEPTH);
  localparam int HALF_W = ACC_W / 2;

  op_e               op;
  logic              en_mask;
  logic              en_std;
  logic [RF_W-1:0]   rs1_full;
  logic [DATA_W-1:0] rs1_val;
  logic [DATA_W-1:0] rs2_val;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] mem_rd;
  logic [ACC_W-1:0]  acc;
  logic [DATA_W-1:0] nb_sel;
  logic              wb_en;
  logic [RF_W-1:0]   wb_data;
  logic              mem_we;
  logic              mac_en;
  logic              clr_en;
  logic              ld_en;
  logic              send_en;
  logic [DATA_W-1:0] out_q;
  logic              act_q;

  assign op      = op_e'(instr_op_i);
  assign en_mask = instr_valid_i & mask_i;
  assign en_std  = en_mask & act_q;
  assign rs1_val = rs1_full[DATA_W-1:0];

  simd_pe_regfile #(.WIDTH(RF_W), .DEPTH(RF_DEPTH), .R2_W(DATA_W)) u_rf (
    .clk    (clk),
    .we     (wb_en),
    .waddr  (instr_rd_i),
    .wdata  (wb_data),
    .raddr1 (instr_rs1_i),
    .raddr2 (instr_rs2_i),
    .rdata1 (rs1_full),
    .rdata2 (rs2_val)
  );

  simd_pe_lmem #(.WIDTH(DATA_W), .DEPTH(MEM_DEPTH)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (instr_imm_i[MEM_AW-1:0]),
    .wdata (rs2_val),
    .rdata (mem_rd)
  );

  simd_pe_alu #(.WIDTH(DATA_W)) u_alu (
    .op  (op),
    .a   (rs1_val),
    .b   (rs2_val),
    .imm (instr_imm_i),
    .res (alu_res)
  );

  simd_pe_mac #(.WIDTH(DATA_W), .ACC_W(ACC_W), .LD_W(RF_W)) u_mac (
    .clk    (clk),
    .rst    (rst),
    .mac_en (mac_en),
    .clr_en (clr_en),
    .ld_en  (ld_en),
    .a      (rs1_val),
    .b      (rs2_val),
    .ld_val (rs1_full),
    .acc    (acc)
  );

  always_comb begin
    unique case (dir_e'(instr_imm_i[1:0]))
      DIR_N:   nb_sel = nb_n_i;
      DIR_E:   nb_sel = nb_e_i;
      DIR_S:   nb_sel = nb_s_i;
      default: nb_sel = nb_w_i;
    endcase
  end

  always_comb begin
    wb_en   = 1'b0;
    wb_data = '0;
    mem_we  = 1'b0;
    mac_en  = 1'b0;
    clr_en  = 1'b0;
    ld_en   = 1'b0;
    send_en = 1'b0;
    if (en_std) begin
      unique case (op)
        OP_ADD, OP_SUB, OP_ADDI, OP_AND, OP_OR, OP_XOR,
        OP_SHL, OP_SHR, OP_SRA, OP_LDI: begin
          wb_en   = 1'b1;
          wb_data = RF_W'(alu_res);
        end
        OP_LD: begin
          wb_en   = 1'b1;
          wb_data = RF_W'(mem_rd);
        end
        OP_ST:   mem_we = 1'b1;
        OP_MAC:  mac_en = 1'b1;
        OP_ACLR: clr_en = 1'b1;
        OP_ALD:  ld_en  = 1'b1;
        OP_AHI: begin
          wb_en   = 1'b1;
          wb_data = RF_W'(acc[ACC_W-1:HALF_W]);
        end
        OP_ALO: begin
          wb_en   = 1'b1;
          wb_data = RF_W'(acc[HALF_W-1:0]);
        end
        OP_AMOV: begin
          wb_en   = 1'b1;
          wb_data = RF_W'(acc);
        end
        OP_SEND: send_en = 1'b1;
        OP_RECV: begin
          wb_en   = 1'b1;
          wb_data = RF_W'(nb_sel);
        end
        OP_SAMP: begin
          wb_en   = 1'b1;
          wb_data = RF_W'(pix_i);
        end
        default: wb_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          out_q <= '0;
    else if (send_en) out_q <= rs1_val;
  end

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b1;
    else if (en_mask) begin
      if (op == OP_MNZ)       act_q <= (rs1_val != '0);
      else if (op == OP_MALL) act_q <= 1'b1;
    end
  end

  assign nb_out_o = out_q;
  assign act_o    = act_q;

endmodule

// File: rtl/simd_pe_chk.sv
module simd_pe_chk
  import simd_pe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid_i,
  input logic [OP_W-1:0]   instr_op_i,
  input logic              mask_i,
  input logic [DATA_W-1:0] nb_out_o,
  input logic              act_o,
  input logic [DATA_W-1:0] rs1_val,
  input logic [ACC_W-1:0]  acc
);

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (instr_valid_i && !mask_i) |=> ($stable(nb_out_o) && $stable(act_o) && $stable(acc)))
    else $error("array enable low changed state");

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !instr_valid_i |=> ($stable(nb_out_o) && $stable(act_o) && $stable(acc)))
    else $error("idle cycle changed state");

  assert_send_value_R8: assert property (@(posedge clk) disable iff (rst)
    (instr_valid_i && mask_i && act_o && instr_op_i == OP_SEND) |=> (nb_out_o == $past(rs1_val)))
    else $error("send did not reach the neighbour output");

  assert_mall_sets_R10: assert property (@(posedge clk) disable iff (rst)
    (instr_valid_i && mask_i && instr_op_i == OP_MALL) |=> act_o)
    else $error("activate-all left the flag low");

  assert_acc_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (instr_valid_i && mask_i && act_o && instr_op_i == OP_ACLR) |=> (acc == '0))
    else $error("accumulator not cleared");

endmodule

bind simd_pe simd_pe_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .instr_valid_i (instr_valid_i),
  .instr_op_i    (instr_op_i),
  .mask_i        (mask_i),
  .nb_out_o      (nb_out_o),
  .act_o         (act_o),
  .rs1_val       (rs1_val),
  .acc           (acc)
);

// File: tb/test_simd_pe.sv
`timescale 1ns/1ps
module test_simd_pe;
  import simd_pe_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [4:0]  op = '0;
  logic [3:0]  rd = '0, rs1 = '0, rs2 = '0;
  logic [15:0] imm = '0;
  logic        mask = 1'b1;
  logic [7:0]  pix = '0;
  logic [15:0] nbn = '0, nbe = '0, nbs = '0, nbw = '0;
  logic [15:0] nb_out;
  logic        act;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_rf [16];
  logic [15:0] m_mem [64];
  logic [31:0] m_acc;
  logic        m_act;
  logic [15:0] m_out;

  always #5 clk = ~clk;

  simd_pe i_simd_pe (
    .clk(clk), .rst(rst), .instr_valid_i(valid), .instr_op_i(op),
    .instr_rd_i(rd), .instr_rs1_i(rs1), .instr_rs2_i(rs2), .instr_imm_i(imm),
    .mask_i(mask), .pix_i(pix), .nb_n_i(nbn), .nb_e_i(nbe), .nb_s_i(nbs),
    .nb_w_i(nbw), .nb_out_o(nb_out), .act_o(act)
  );

  function automatic logic [15:0] f_alu(input logic [4:0] o, input logic [15:0] a,
                                        input logic [15:0] b, input logic [15:0] k);
    case (o)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_ADDI: return a + k;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_SHL:  return a << k[3:0];
      OP_SHR:  return a >> k[3:0];
      OP_SRA:  return 16'($signed(a) >>> k[3:0]);
      default: return k;
    endcase
  endfunction

  task automatic model(input logic v, input logic mk, input logic [4:0] o, input logic [3:0] d,
                       input logic [3:0] s1, input logic [3:0] s2, input logic [15:0] k);
    logic [15:0] a, b;
    logic signed [31:0] p;
    a = m_rf[s1][15:0];
    b = m_rf[s2][15:0];
    p = $signed(a) * $signed(b);
    if (!(v && mk)) return;
    if (o == OP_MNZ) begin m_act = (a != 0); return; end
    if (o == OP_MALL) begin m_act = 1'b1; return; end
    if (!m_act) return;
    case (o)
      OP_ADD, OP_SUB, OP_ADDI, OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR, OP_SRA, OP_LDI:
        m_rf[d] = {16'h0, f_alu(o, a, b, k)};
      OP_LD:   m_rf[d] = {16'h0, m_mem[k[5:0]]};
      OP_ST:   m_mem[k[5:0]] = b;
      OP_MAC:  m_acc = m_acc + p;
      OP_ACLR: m_acc = '0;
      OP_AHI:  m_rf[d] = {16'h0, m_acc[31:16]};
      OP_ALO:  m_rf[d] = {16'h0, m_acc[15:0]};
      OP_AMOV: m_rf[d] = m_acc;
      OP_ALD:  m_acc = m_rf[s1];
      OP_SEND: m_out = a;
      OP_RECV: m_rf[d] = {16'h0, (k[1:0] == 2'd0) ? nbn : (k[1:0] == 2'd1) ? nbe :
                                 (k[1:0] == 2'd2) ? nbs : nbw};
      OP_SAMP: m_rf[d] = {24'h0, pix};
      default: ;
    endcase
  endtask

  task automatic issue(input logic v, input logic mk, input logic [4:0] o, input logic [3:0] d,
                       input logic [3:0] s1, input logic [3:0] s2, input logic [15:0] k);
    @(negedge clk);
    valid = v; mask = mk; op = o; rd = d; rs1 = s1; rs2 = s2; imm = k;
    model(v, mk, o, d, s1, s2, k);
    @(posedge clk);
  endtask

  task automatic chk16(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // send register r and compare the neighbour output with the model
  task automatic peek(input string req, input logic [3:0] r);
    issue(1'b1, 1'b1, OP_SEND, 4'd0, r, 4'd0, 16'd0);
    @(negedge clk);
    valid = 1'b0;
    chk16(req, nb_out, m_out);
    chk16({req, " act"}, {15'd0, act}, {15'd0, m_act});
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    m_acc = '0; m_act = 1'b1; m_out = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk16("R1 out", nb_out, 16'h0);
    chk16("R1 act", {15'd0, act}, 16'd1);
    issue(1'b1, 1'b1, OP_ALO, 4'd0, 4'd0, 4'd0, 16'd0);
    peek("R1 acc", 4'd0);

    for (int i = 0; i < 16; i++) issue(1'b1, 1'b1, OP_LDI, 4'(i), 4'd0, 4'd0, 16'($urandom));
    peek("R2 ldi", 4'd7);

    // R2 wrap
    issue(1'b1, 1'b1, OP_LDI, 4'd1, 4'd0, 4'd0, 16'hFFFF);
    issue(1'b1, 1'b1, OP_LDI, 4'd2, 4'd0, 4'd0, 16'h0001);
    issue(1'b1, 1'b1, OP_ADD, 4'd3, 4'd1, 4'd2, 16'd0);
    peek("R2 add wrap", 4'd3);
    issue(1'b1, 1'b1, OP_SUB, 4'd4, 4'd2, 4'd1, 16'd0);
    peek("R2 sub wrap", 4'd4);

    // R3 shifts
    issue(1'b1, 1'b1, OP_LDI, 4'd5, 4'd0, 4'd0, 16'h8001);
    issue(1'b1, 1'b1, OP_SRA, 4'd6, 4'd5, 4'd0, 16'd4);
    peek("R3 sra", 4'd6);
    issue(1'b1, 1'b1, OP_SHR, 4'd6, 4'd5, 4'd0, 16'd15);
    peek("R3 shr", 4'd6);
    issue(1'b1, 1'b1, OP_SHL, 4'd6, 4'd5, 4'd0, 16'd15);
    peek("R3 shl", 4'd6);

    // R4 signed multiply-accumulate
    issue(1'b1, 1'b1, OP_ACLR, 4'd0, 4'd0, 4'd0, 16'd0);
    issue(1'b1, 1'b1, OP_MAC, 4'd0, 4'd1, 4'd1, 16'd0);
    issue(1'b1, 1'b1, OP_LDI, 4'd7, 4'd0, 4'd0, 16'h7FFF);
    issue(1'b1, 1'b1, OP_MAC, 4'd0, 4'd7, 4'd7, 16'd0);
    issue(1'b1, 1'b1, OP_AHI, 4'd8, 4'd0, 4'd0, 16'd0);
    peek("R4 acc high", 4'd8);
    issue(1'b1, 1'b1, OP_ALO, 4'd8, 4'd0, 4'd0, 16'd0);
    peek("R4 acc low", 4'd8);
    issue(1'b1, 1'b1, OP_AMOV, 4'd12, 4'd0, 4'd0, 16'd0);
    issue(1'b1, 1'b1, OP_ACLR, 4'd0, 4'd0, 4'd0, 16'd0);
    issue(1'b1, 1'b1, OP_ALD, 4'd0, 4'd12, 4'd0, 16'd0);
    issue(1'b1, 1'b1, OP_AHI, 4'd13, 4'd0, 4'd0, 16'd0);
    peek("R4 move and load", 4'd13);

    // R5 memory: fill every word, read the ends back
    for (int a = 0; a < 64; a++) begin
      issue(1'b1, 1'b1, OP_LDI, 4'd9, 4'd0, 4'd0, 16'($urandom));
      issue(1'b1, 1'b1, OP_ST, 4'd0, 4'd0, 4'd9, 16'(a));
    end
    issue(1'b1, 1'b1, OP_LD, 4'd10, 4'd0, 4'd0, 16'd63);
    peek("R5 load top", 4'd10);
    issue(1'b1, 1'b1, OP_LD, 4'd10, 4'd0, 4'd0, 16'd0);
    peek("R5 load bottom", 4'd10);

    // R6 neighbour selection
    nbn = 16'h1111; nbe = 16'h2222; nbs = 16'h3333; nbw = 16'h4444;
    for (int dsel = 0; dsel < 4; dsel++) begin
      issue(1'b1, 1'b1, OP_RECV, 4'd11, 4'd0, 4'd0, 16'(dsel));
      peek("R6 recv", 4'd11);
    end

    // R7 pixel sample
    pix = 8'hA5;
    issue(1'b1, 1'b1, OP_SAMP, 4'd11, 4'd0, 4'd0, 16'd0);
    peek("R7 sample", 4'd11);

    // R8 output holds through other instructions
    issue(1'b1, 1'b1, OP_ADD, 4'd3, 4'd1, 4'd1, 16'd0);
    @(negedge clk); valid = 1'b0;
    chk16("R8 hold", nb_out, m_out);

    // R9 array enable low
    issue(1'b1, 1'b0, OP_LDI, 4'd11, 4'd0, 4'd0, 16'hBEEF);
    issue(1'b1, 1'b0, OP_ST, 4'd0, 4'd0, 4'd2, 16'd5);
    issue(1'b1, 1'b0, OP_MAC, 4'd0, 4'd7, 4'd7, 16'd0);
    issue(1'b1, 1'b0, OP_SEND, 4'd0, 4'd7, 4'd0, 16'd0);
    @(negedge clk); valid = 1'b0;
    chk16("R9 out", nb_out, m_out);
    peek("R9 reg", 4'd11);
    issue(1'b1, 1'b1, OP_LD, 4'd10, 4'd0, 4'd0, 16'd5);
    peek("R9 mem", 4'd10);
    issue(1'b1, 1'b1, OP_ALO, 4'd10, 4'd0, 4'd0, 16'd0);
    peek("R9 acc", 4'd10);

    // R10 activity flag
    issue(1'b1, 1'b1, OP_LDI, 4'd14, 4'd0, 4'd0, 16'd0);
    issue(1'b1, 1'b1, OP_MNZ, 4'd0, 4'd14, 4'd0, 16'd0);
    issue(1'b1, 1'b1, OP_LDI, 4'd15, 4'd0, 4'd0, 16'h5A5A);
    peek("R10 suppressed", 4'd15);
    issue(1'b1, 1'b1, OP_MALL, 4'd0, 4'd0, 4'd0, 16'd0);
    peek("R10 reactivated", 4'd15);

    // R11 valid low
    issue(1'b0, 1'b1, OP_LDI, 4'd15, 4'd0, 4'd0, 16'hC0DE);
    issue(1'b0, 1'b1, OP_ACLR, 4'd0, 4'd0, 4'd0, 16'd0);
    peek("R11 idle reg", 4'd15);
    issue(1'b1, 1'b1, OP_ALO, 4'd15, 4'd0, 4'd0, 16'd0);
    peek("R11 idle acc", 4'd15);

    // R12 back-to-back dependency
    issue(1'b1, 1'b1, OP_LDI, 4'd9, 4'd0, 4'd0, 16'd5);
    issue(1'b1, 1'b1, OP_ADDI, 4'd10, 4'd9, 4'd0, 16'd3);
    issue(1'b1, 1'b1, OP_XOR, 4'd10, 4'd10, 4'd9, 16'd0);
    peek("R12 forward", 4'd10);

    // random mix across R2..R10
    for (int it = 0; it < 400; it++) begin
      nbn = 16'($urandom); nbe = 16'($urandom); nbs = 16'($urandom); nbw = 16'($urandom);
      pix = 8'($urandom);
      issue(1'b1, ($urandom_range(0, 6) != 0), 5'($urandom_range(1, 23)),
            4'($urandom), 4'($urandom), 4'($urandom), 16'($urandom));
      peek("R2-mix random", 4'($urandom));
      if (it % 50 == 49) begin
        issue(1'b1, 1'b1, OP_AMOV, 4'd0, 4'd0, 4'd0, 16'd0);
        peek("R4 random acc", 4'd0);
      end
    end

    finish_run();
  end

endmodule